// File: doc/BRIEF.md
# Serial Output Freeze Controller

This block sits between a set of divided output clocks and the pins that carry them. A slow serial clock and a data line carry a framed control word. Each bit of the word decides whether one output clock keeps toggling or is parked low. The twelve gated clocks are switched cleanly: a clock that is being stopped finishes its current high phase, and a clock that is being restarted waits for its next natural rising edge. No shortened pulse reaches an output.

A frame opens with a low start bit. Twelve enable bits follow, one per rising edge of the serial clock. Nothing changes at the outputs while a frame is still arriving. The whole word takes effect on the rising edge after the last bit. The bit sampled on that same edge can open the next frame, so words may be streamed back to back. Each loaded enable bit crosses into its own output clock domain through a synchroniser before it reaches that clock's gate. Two further clocks, the first clock of the third bank and the feedback clock, cannot be stopped and go straight to their outputs.

Top module: `frz_gate_ctrl`

## Requirements
- R1: A frame is one low start bit followed by twelve enable bits, all sampled on rising edges of `ser_clk`.
- R2: The k-th enable bit after the start bit (k = 0..11) controls `gated_clk[k]`. Indices 0-3 are the first bank, 4-7 the second bank, 8-10 the last three clocks of the third bank, and 11 the sync clock.
- R3: An enable bit of 1 lets its output follow `src_clk`. A value of 0 holds the output low while its `src_clk` keeps toggling.
- R4: While a frame is incomplete, the outputs keep the previous word, however long the serial clock pauses. The new word is loaded on the rising edge after the twelfth bit.
- R5: A 0 sampled on the load edge is the start bit of the next frame, so frames may follow each other without idle bits.
- R6: A 1 sampled on the load edge, and any further 1s, leave the receiver idle. Ones on `ser_din` between frames do not change any output.
- R7: A stopped output goes low only together with a falling edge of its `src_clk`. Every high pulse on `gated_clk` lasts exactly one high phase of its source.
- R8: A restarted output goes high only together with a rising edge of its `src_clk`. It never emits a partial high phase.
- R9: While `rst_n` is low and after it is released, all twelve outputs run, until a frame arrives.
- R10: `pass_out` always equals `pass_clk`, whatever the serial word is.
- R11: A loaded setting reaches each gated output within four periods of that output's own `src_clk` after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for receiver, synchronisers and gates |
| ser_clk | input | 1 | Serial control clock, up to 20 MHz |
| ser_din | input | 1 | Serial control data, start bit then twelve enable bits |
| src_clk | input | 12 | Free-running divided clocks to be gated |
| pass_clk | input | 2 | Clocks that cannot be stopped |
| gated_clk | output | 12 | Gated copies of `src_clk` |
| pass_out | output | 2 | Unchanged copies of `pass_clk` |

## Verification
The assertions assume that `ser_din` is stable around each rising edge of `ser_clk`. They also assume that every `src_clk` is a free-running clock whose edges never coincide with a change of `rst_n`. Reset is applied only once, before any frame, because an asynchronous reset in the middle of a high phase would legitimately restart a stopped clock early. The stimulus drives `ser_din` only on falling edges of the serial clock and pauses that clock only in its low phase. It derives all source clocks from one base clock and samples every output on the opposite edge of that base clock, where all source levels are settled.

// File: rtl/frz_pkg.sv
package frz_pkg;

   // receiver phases; the load phase lasts exactly one serial clock
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SHIFT = 2'd1,
      PH_LOAD  = 2'd2
   } rx_phase_e;

endpackage

// File: rtl/frz_serial_rx.sv
module frz_serial_rx
   import frz_pkg::*;
#(
   parameter int                WORD_W   = 12,
   parameter logic [WORD_W-1:0] RST_WORD = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   output logic [WORD_W-1:0] en_word,
   output rx_phase_e         phase
);

   localparam int              CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] word_q;
   rx_phase_e         phase_q;

   // first bit received ends up in index 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         bit_cnt <= '0;
         shreg   <= '1;
         word_q  <= RST_WORD;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (!din) begin
                  phase_q <= PH_SHIFT;
                  bit_cnt <= '0;
               end
            end
            PH_SHIFT: begin
               shreg <= {din, shreg[WORD_W-1:1]};
               if (bit_cnt == LAST) begin
                  phase_q <= PH_LOAD;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            PH_LOAD: begin
               word_q  <= shreg;
               bit_cnt <= '0;
               phase_q <= din ? PH_IDLE : PH_SHIFT;
            end
            default: begin
               phase_q <= PH_IDLE;
            end
         endcase
      end
   end

   assign en_word = word_q;
   assign phase   = phase_q;

endmodule

// File: rtl/frz_sync.sv
module frz_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/frz_clk_gate.sv
module frz_clk_gate #(
   parameter logic RST_EN = 1'b1
) (
   input  logic clk_in,
   input  logic rst_n,
   input  logic en,
   output logic clk_out
);

   logic en_low;

   // enable captured only at the falling edge, held through the high phase
   always_ff @(negedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         en_low <= RST_EN;
      end else begin
         en_low <= en;
      end
   end

   assign clk_out = clk_in & en_low;

endmodule

// File: rtl/frz_gate_ctrl.sv
module frz_gate_ctrl
   import frz_pkg::*;
#(
   parameter int                   NUM_GATED   = 12,
   parameter int                   NUM_PASS    = 2,
   parameter int                   SYNC_STAGES = 2,
   parameter logic [NUM_GATED-1:0] RST_WORD    = '1
) (
   input  logic                 rst_n,
   input  logic                 ser_clk,
   input  logic                 ser_din,
   input  logic [NUM_GATED-1:0] src_clk,
   input  logic [NUM_PASS-1:0]  pass_clk,
   output logic [NUM_GATED-1:0] gated_clk,
   output logic [NUM_PASS-1:0]  pass_out
);

   if (NUM_GATED < 2) begin : g_chk_width
      $error("frz_gate_ctrl: NUM_GATED must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("frz_gate_ctrl: SYNC_STAGES must be at least 2");
   end
   if (NUM_PASS < 1) begin : g_chk_pass
      $error("frz_gate_ctrl: NUM_PASS must be at least 1");
   end

   logic [NUM_GATED-1:0] en_word;
   logic [NUM_GATED-1:0] en_sync;
   rx_phase_e            rx_phase;

   frz_serial_rx #(
      .WORD_W   (NUM_GATED),
      .RST_WORD (RST_WORD)
   ) rx_i (
      .clk     (ser_clk),
      .rst_n   (rst_n),
      .din     (ser_din),
      .en_word (en_word),
      .phase   (rx_phase)
   );

   for (genvar gi = 0; gi < NUM_GATED; gi++) begin : g_lane
      frz_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (RST_WORD[gi])
      ) sync_i (
         .clk   (src_clk[gi]),
         .rst_n (rst_n),
         .d     (en_word[gi]),
         .q     (en_sync[gi])
      );

      frz_clk_gate #(
         .RST_EN (RST_WORD[gi])
      ) gate_i (
         .clk_in  (src_clk[gi]),
         .rst_n   (rst_n),
         .en      (en_sync[gi]),
         .clk_out (gated_clk[gi])
      );
   end

   assign pass_out = pass_clk;

endmodule

// File: rtl/frz_gate_ctrl_chk.sv
module frz_gate_ctrl_chk
   import frz_pkg::*;
#(
   parameter int N = 12
) (
   input logic         rst_n,
   input logic         ser_clk,
   input logic         ser_din,
   input logic [N-1:0] src_clk,
   input logic [N-1:0] gated_clk,
   input logic [N-1:0] en_word,
   input rx_phase_e    rx_phase
);

   AST_START_SEEN: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (rx_phase == PH_IDLE && !ser_din) |=> (rx_phase == PH_SHIFT)) else $error("start bit missed"); // R1

   AST_WORD_HELD: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (rx_phase != PH_LOAD) |=> $stable(en_word)) else $error("word changed mid-frame"); // R4

   AST_CHAINED_FRAME: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (rx_phase == PH_LOAD && !ser_din) |=> (rx_phase == PH_SHIFT)) else $error("chained start lost"); // R5

   AST_IDLE_ON_ONES: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (rx_phase == PH_IDLE && ser_din) |=> (rx_phase == PH_IDLE)) else $error("left idle on a one"); // R6

   AST_LOAD_ONE_CYCLE: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (rx_phase == PH_LOAD) |=> (rx_phase != PH_LOAD)) else $error("load phase repeated"); // R4

   for (genvar gi = 0; gi < N; gi++) begin : g_out
      always @(negedge gated_clk[gi]) begin
         if (rst_n) begin
            AST_FALL_WITH_SRC: assert (!src_clk[gi]) else $error("output %0d fell early", gi); // R7
         end
      end
   end

endmodule

bind frz_gate_ctrl frz_gate_ctrl_chk #(.N(NUM_GATED)) chk_i (
   .rst_n     (rst_n),
   .ser_clk   (ser_clk),
   .ser_din   (ser_din),
   .src_clk   (src_clk),
   .gated_clk (gated_clk),
   .en_word   (en_word),
   .rx_phase  (rx_phase)
);

// File: tb/frz_gate_ctrl_tb_top.sv
module frz_gate_ctrl_tb_top;

   localparam int N           = 12;
   localparam int NP          = 2;
   localparam int SER_PERIOD  = 50;
   localparam int BASE_PERIOD = 4;
   localparam int SETTLE      = 400;
   localparam int WIN         = 60;
   localparam int LIMIT       = 200000;
   localparam int NVEC        = 7;

   // entry: {word to send, trailing ones, expected enable pattern}
   localparam logic [27:0] VEC [NVEC] = '{
      {12'h000, 4'd3, 12'h000},
      {12'hFFF, 4'd2, 12'hFFF},
      {12'h001, 4'd1, 12'h001},
      {12'h800, 4'd4, 12'h800},
      {12'hA5C, 4'd2, 12'hA5C},
      {12'h3F0, 4'd5, 12'h3F0},
      {12'h7FE, 4'd1, 12'h7FE}
   };

   logic          rst_n   = 1'b1;
   logic          ser_clk = 1'b0;
   logic          ser_run = 1'b1;
   logic          ser_din = 1'b1;
   logic          base_clk = 1'b0;
   logic [N-1:0]  src_clk  = '0;
   logic [NP-1:0] pass_clk = '0;
   logic [N-1:0]  gated_clk;
   logic [NP-1:0] pass_out;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;
   logic [N-1:0] cur = '1;
   int div_cnt [N] = '{default: 0};

   frz_gate_ctrl dut_i (
      .rst_n     (rst_n),
      .ser_clk   (ser_clk),
      .ser_din   (ser_din),
      .src_clk   (src_clk),
      .pass_clk  (pass_clk),
      .gated_clk (gated_clk),
      .pass_out  (pass_out)
   );

   always #(BASE_PERIOD/2) base_clk = ~base_clk;

   // serial clock stops only in its low phase
   initial forever begin
      #(SER_PERIOD/2);
      if (ser_run || ser_clk) ser_clk = ~ser_clk;
   end

   // source i toggles every (i%3)+1 base cycles
   always @(posedge base_clk) begin
      pass_clk <= pass_clk + 1'b1;
      for (int i = 0; i < N; i++) begin
         if (div_cnt[i] >= i % 3) begin
            div_cnt[i] <= 0;
            src_clk[i] <= ~src_clk[i];
         end else begin
            div_cnt[i] <= div_cnt[i] + 1;
         end
      end
   end

   // pulse-width monitor for R7 and R8
   logic [N-1:0] prev_g = '0;
   time          t_rise [N];
   bit           seen   [N];
   int           runts  [N] = '{default: 0};

   always @(gated_clk) begin
      for (int i = 0; i < N; i++) begin
         if (gated_clk[i] === 1'b1 && prev_g[i] !== 1'b1) begin
            t_rise[i] = $time;
            seen[i]   = 1'b1;
         end else if (gated_clk[i] === 1'b0 && prev_g[i] === 1'b1 && seen[i]) begin
            if (($time - t_rise[i]) != time'((i % 3 + 1) * BASE_PERIOD)) runts[i]++;
         end
      end
      prev_g = gated_clk;
   end

   task automatic bit_out(input logic v);
      @(negedge ser_clk);
      ser_din = v;
   endtask

   task automatic send_word(input logic [N-1:0] w, input int trail);
      bit_out(1'b0);
      for (int b = 0; b < N; b++) bit_out(w[b]);
      for (int t = 0; t < trail; t++) bit_out(1'b1);
   endtask

   task automatic check_pattern(input logic [N-1:0] exp, input string req);
      int bad [N];
      logic [N-1:0] last_act;
      int bad_p;
      logic [NP-1:0] last_p;
      logic [NP-1:0] last_pe;
      bad_p = 0;
      last_act = '0;
      last_p = '0;
      last_pe = '0;
      for (int i = 0; i < N; i++) bad[i] = 0;
      for (int s = 0; s < WIN; s++) begin
         @(negedge base_clk);
         for (int i = 0; i < N; i++) begin
            if (gated_clk[i] !== (src_clk[i] & exp[i])) begin
               bad[i]++;
               last_act[i] = gated_clk[i];
            end
         end
         if (pass_out !== pass_clk) begin
            bad_p++;
            last_p  = pass_out;
            last_pe = pass_clk;
         end
      end
      for (int i = 0; i < N; i++) begin
         checks++;
         if (bad[i] != 0) begin
            errors++;
            $display("FAIL %s: gated_clk[%0d] wrong in %0d samples, actual=%b expected=%b (enable %b)",
                     req, i, bad[i], last_act[i], ~last_act[i], exp[i]);
         end
      end
      checks++;
      if (bad_p != 0) begin
         errors++;
         $display("FAIL R10: pass_out wrong in %0d samples, actual=%b expected=%b", bad_p, last_p, last_pe);
      end
   endtask

   initial begin
      #1 rst_n = 1'b0;
      // R9: outputs run while held in reset
      check_pattern('1, "R9");
      @(negedge ser_clk);
      rst_n = 1'b1;
      #(SER_PERIOD);
      check_pattern('1, "R9");

      // table walk: R1 R2 R3 R6
      for (int v = 0; v < NVEC; v++) begin
         send_word(VEC[v][27:16], int'(VEC[v][15:12]));
         #(SETTLE);
         check_pattern(VEC[v][11:0], "R1 R2 R3");
         cur = VEC[v][11:0];
      end

      // R6: a long run of ones changes nothing
      for (int t = 0; t < 40; t++) bit_out(1'b1);
      #(SETTLE);
      check_pattern(cur, "R6");

      // R4: incomplete frame with a paused serial clock
      bit_out(1'b0);
      for (int b = 0; b < N - 1; b++) bit_out(~cur[b]);
      @(negedge ser_clk);
      ser_run = 1'b0;
      #(3 * SETTLE);
      check_pattern(cur, "R4");
      ser_din = ~cur[N-1];
      ser_run = 1'b1;
      for (int t = 0; t < 3; t++) bit_out(1'b1);
      #(SETTLE);
      cur = ~cur;
      check_pattern(cur, "R4");

      // R5: two frames back to back, second begins with a 0 data bit
      send_word(12'h0F3, 0);
      send_word(12'h5A6, 2);
      #(SETTLE);
      cur = 12'h5A6;
      check_pattern(cur, "R5");

      // R11: latency bound, checked four slowest periods after the load edge
      send_word(12'hC3B, 1);
      #(SER_PERIOD/2 + 4 * 3 * 2 * BASE_PERIOD + 2);
      cur = 12'hC3B;
      check_pattern(cur, "R11");

      // R7 R8: no shortened high pulse anywhere
      for (int i = 0; i < N; i++) begin
         checks++;
         if (runts[i] != 0) begin
            errors++;
            $display("FAIL R7 R8: gated_clk[%0d] short pulses actual=%0d expected=0", i, runts[i]);
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(LIMIT);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not end, actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule